// File: doc/BRIEF.md
# Zero-Run Clock Phase Resynchronizer

This block brings a free-running internal frame-phase counter back into line with an external frame clock. It does so only at moments when a phase jump cannot damage audio. Those moments are a long stretch of silence on both channels of a stereo sample stream, or a software-requested digital reset. The block watches each channel for an unbroken run of zero samples and raises a per-channel zero flag once the run is long enough. When both flags are up and syncing is enabled, it waits for the selected edge of the external clock. If the internal counter is not at its zero phase on that edge, it reloads the counter and emits a one-cycle reset pulse.

After each such reload, the outgoing sample stream is forced to zero for a few sample strobes. The soft-reset control has a sequence of its own:
- Lowering the control bit raises both zero flags at once.
- The internal digital reset then follows the bit after a fixed number of sample strobes.
- The flags fall again a couple of strobes after the digital reset has been released.

The block sits between a sample interface and the downstream filter path, and runs in the system clock domain.

Top module: `zrun_phase_resync`

## Requirements
- R1: Each channel has its own zero flag, which rises one clock after that channel's ZERO_RUN-th consecutive all-zero sample strobe. Any nonzero sample on that channel restarts its run. A full run saturates and keeps the flag up.
- R2: `edge_mode` selects which external edge aligns the counter: 0 is the rising edge of `frame_clk`, 1 is the falling edge of `frame_clk` (I2S framing), 2 is the rising edge of `word_clk`, and 3 acts as 0. The pin passes through a two-flop synchronizer, so `phase_rst` is high after the third clock edge that samples the pin change.
- R3: A counter reload happens only while `sync_en` is high and both zero flags are high. A reload shows as a one-cycle `phase_rst` pulse, and `phase_cnt` is loaded with 1.
- R4: When the selected edge finds `phase_cnt` already at 0, no pulse is issued and the counter is left alone, even with realignment enabled.
- R5: The FORCE_N sample strobes that follow a reload pulse produce zero output samples. If the reload coincides with a strobe, that sample is passed unchanged.
- R6: While `soft_run` is 0, both zero flags are high from the next clock, and realignment is enabled.
- R7: After `soft_run` falls, `dig_rst` rises at the 3rd following sample strobe. After `soft_run` rises, `dig_rst` falls at the 2nd following sample strobe. `dig_rst` changes only at strobes.
- R8: Flags raised by the soft reset stay up until the 2nd sample strobe after `dig_rst` has fallen. They drop one clock after that strobe, unless a zero run holds them up.
- R9: With `sync_en` low, `phase_rst` never pulses.
- R10: Every sample strobe produces `out_valid` for one cycle, one clock later. The output carries the input sample, or zero while `dig_rst` is high or a forcing window (R5) is open.
- R11: Between reloads, `phase_cnt` increments every clock and wraps at 2^PHASE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_l | input | DATA_W | Left sample word |
| smp_r | input | DATA_W | Right sample word |
| frame_clk | input | 1 | External frame clock (asynchronous) |
| word_clk | input | 1 | External word clock (asynchronous) |
| edge_mode | input | 2 | Alignment edge select (see R2) |
| sync_en | input | 1 | Enables realignment |
| soft_run | input | 1 | Soft-reset control bit, 0 requests digital reset |
| zero_flag_l | output | 1 | Left zero-run flag |
| zero_flag_r | output | 1 | Right zero-run flag |
| phase_rst | output | 1 | One-cycle counter reload pulse |
| phase_cnt | output | PHASE_W | Internal phase counter |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | DATA_W | Left output sample |
| out_r | output | DATA_W | Right output sample |
| dig_rst | output | 1 | Internal digital reset |

## Verification
On every cycle, the assertions check four things:
- a reload pulse only appears while realignment was enabled and the counter was off phase;
- syncing disabled means no pulse;
- a low soft-reset bit raises both flags on the next clock;
- `dig_rst` moves only on a strobe, and a zero flag only rises on a zero sample.

The bench scenarios are what show the rest. They show which edge each mode picks and the exact cycle of the pulse within the frame. They show that an aligned counter is left untouched, that the zero window after a reload is exactly FORCE_N samples long, and that the soft-reset strobe counts in both directions, including the delayed fall of the flags.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_I2S = 2'd1,
    MODE_WCK = 2'd2,
    MODE_RSV = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/zrun_run_detect.sv
module zrun_run_detect #(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp,
  output logic              run_full
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] run_cnt;

  assign run_full = (run_cnt == CW'(RUN_LEN));

  // restart on any nonzero word, saturate at the terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (smp_valid) begin
      if (smp != '0)     run_cnt <= '0;
      else if (!run_full) run_cnt <= run_cnt + CW'(1);
    end
  end

  assert_full_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(run_full) |-> ($past(smp_valid) && ($past(smp) == '0)));
endmodule

// File: rtl/zrun_edge_pick.sv
module zrun_edge_pick
  import zrun_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_clk,
  input  logic       word_clk,
  input  edge_mode_e mode,
  output logic       edge_hit
);
  localparam int NSRC = 2;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] rise, fall;

  assign src = {word_clk, frame_clk};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // stages 0..SYNC_STAGES-1 synchronize, the last stage holds history
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SYNC_STAGES-1:0], src[g]};
    end
    assign rise[g] =  sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    assign fall[g] = ~sh[SYNC_STAGES-1] &  sh[SYNC_STAGES];
  end

  always_comb begin
    unique case (mode)
      MODE_I2S: edge_hit = fall[0];
      MODE_WCK: edge_hit = rise[1];
      default:  edge_hit = rise[0];
    endcase
  end
endmodule

// File: rtl/zrun_softrst_seq.sv
module zrun_softrst_seq #(
  parameter int ASSERT_DLY  = 3,
  parameter int RELEASE_DLY = 2,
  parameter int TAIL_LEN    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic soft_run,
  output logic dig_rst,
  output logic hold_req
);
  localparam int MAXD = (ASSERT_DLY > RELEASE_DLY) ? ASSERT_DLY : RELEASE_DLY;
  localparam int DW   = $clog2(MAXD + 1);
  localparam int TW   = $clog2(TAIL_LEN + 1);

  logic          run_q;
  logic          pend, pend_tgt;
  logic [DW-1:0] pend_cnt;
  logic          hold_q;
  logic [TW-1:0] tail_cnt;

  assign hold_req = hold_q | ~soft_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b1;
      pend     <= 1'b0;
      pend_tgt <= 1'b0;
      pend_cnt <= '0;
      dig_rst  <= 1'b0;
    end else begin
      run_q <= soft_run;
      if (soft_run != run_q) begin
        pend     <= 1'b1;
        pend_tgt <= ~soft_run;
        pend_cnt <= soft_run ? DW'(RELEASE_DLY) : DW'(ASSERT_DLY);
      end else if (pend && smp_valid) begin
        if (pend_cnt == DW'(1)) begin
          dig_rst <= pend_tgt;
          pend    <= 1'b0;
        end
        pend_cnt <= pend_cnt - DW'(1);
      end
    end
  end

  // flag hold: set while the bit is low, released TAIL_LEN strobes after dig_rst falls
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      tail_cnt <= '0;
    end else if (!soft_run) begin
      hold_q   <= 1'b1;
      tail_cnt <= '0;
    end else if (hold_q && !dig_rst && smp_valid) begin
      if (tail_cnt == TW'(TAIL_LEN - 1)) hold_q <= 1'b0;
      tail_cnt <= tail_cnt + TW'(1);
    end
  end

  assert_dig_rst_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dig_rst) |-> $past(smp_valid));
endmodule

// File: rtl/zrun_phase_resync.sv
module zrun_phase_resync
  import zrun_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 8192,
  parameter int PHASE_W  = 8,
  parameter int FORCE_N  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_l,
  input  logic [DATA_W-1:0] smp_r,
  input  logic              frame_clk,
  input  logic              word_clk,
  input  logic [1:0]        edge_mode,
  input  logic              sync_en,
  input  logic              soft_run,
  output logic              zero_flag_l,
  output logic              zero_flag_r,
  output logic              phase_rst,
  output logic [PHASE_W-1:0] phase_cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r,
  output logic              dig_rst
);
  localparam int NCH = 2;
  localparam int FW  = $clog2(FORCE_N + 1);

  logic [DATA_W-1:0] ch_smp [NCH];
  logic [NCH-1:0]    run_full;
  logic [NCH-1:0]    flag_q;
  logic              hold_req, edge_hit, realign_en, reload;
  logic [FW-1:0]     force_cnt;
  logic              zero_out;

  assign ch_smp[0] = smp_l;
  assign ch_smp[1] = smp_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zrun_run_detect #(.DATA_W(DATA_W), .RUN_LEN(ZERO_RUN)) u_run (
      .clk(clk), .rst(rst), .smp_valid(smp_valid),
      .smp(ch_smp[c]), .run_full(run_full[c])
    );
    always_ff @(posedge clk) begin
      if (rst) flag_q[c] <= 1'b0;
      else     flag_q[c] <= run_full[c] | hold_req;
    end
  end

  assign zero_flag_l = flag_q[0];
  assign zero_flag_r = flag_q[1];

  zrun_edge_pick #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .frame_clk(frame_clk), .word_clk(word_clk),
    .mode(edge_mode_e'(edge_mode)), .edge_hit(edge_hit)
  );

  zrun_softrst_seq #(.ASSERT_DLY(3), .RELEASE_DLY(2), .TAIL_LEN(2)) u_soft (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .soft_run(soft_run),
    .dig_rst(dig_rst), .hold_req(hold_req)
  );

  assign realign_en = sync_en & (&flag_q);
  assign reload     = realign_en & edge_hit & (phase_cnt != '0);

  // phase counter: loading 1 puts value 0 on the next aligned edge
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_cnt <= '0;
      phase_rst <= 1'b0;
    end else begin
      phase_rst <= reload;
      phase_cnt <= reload ? PHASE_W'(1) : phase_cnt + PHASE_W'(1);
    end
  end

  assign zero_out = dig_rst | (force_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      force_cnt <= '0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        out_l <= zero_out ? '0 : smp_l;
        out_r <= zero_out ? '0 : smp_r;
      end
      if (reload)                            force_cnt <= FW'(FORCE_N);
      else if (smp_valid && force_cnt != '0) force_cnt <= force_cnt - FW'(1);
    end
  end

  assert_reload_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    phase_rst |-> $past(realign_en));
  assert_reload_only_off_phase_R4: assert property (@(posedge clk) disable iff (rst)
    phase_rst |-> ($past(phase_cnt) != '0));
  assert_soft_low_flags_R6: assert property (@(posedge clk) disable iff (rst)
    !soft_run |=> (zero_flag_l && zero_flag_r));
  assert_disabled_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !phase_rst);
endmodule

// File: tb/zrun_phase_resync_bench.sv
module zrun_phase_resync_bench;
  localparam int DW = 16, ZR = 16, PW = 4, FN = 3;
  localparam int FL = 1 << PW;

  logic clk = 0, rst = 1;
  logic smp_valid = 0, frame_clk = 0, word_clk = 0, sync_en = 1, soft_run = 1;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic [1:0] edge_mode = 2'd0;
  logic zero_flag_l, zero_flag_r, phase_rst, out_valid, dig_rst;
  logic [PW-1:0] phase_cnt;
  logic [DW-1:0] out_l, out_r;

  always #10 clk = ~clk;

  zrun_phase_resync #(.DATA_W(DW), .ZERO_RUN(ZR), .PHASE_W(PW), .FORCE_N(FN)) u_zrun_phase_resync (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .frame_clk(frame_clk), .word_clk(word_clk), .edge_mode(edge_mode),
    .sync_en(sync_en), .soft_run(soft_run), .zero_flag_l(zero_flag_l),
    .zero_flag_r(zero_flag_r), .phase_rst(phase_rst), .phase_cnt(phase_cnt),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .dig_rst(dig_rst)
  );

  int checks = 0, errors = 0;
  int pulses = 0, last_fcnt = -1, force_left = 0, fcnt = 0;
  bit done = 0;
  logic [2*DW-1:0] sb_q[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: reload pulses and output scoreboard (R5, R10)
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (phase_rst) begin
        pulses++;
        last_fcnt = fcnt;
        force_left = FN;
        chk("R3 counter loaded with 1", int'(phase_cnt), 1);
      end
      if (out_valid) begin
        if (sb_q.size() == 0) chk("R10 unexpected output", 1, 0);
        else chk("R5/R10 output sample", int'({out_l, out_r}), int'(sb_q.pop_front()));
      end
    end
  end

  // driver: one frame of FL clocks, one sample strobe at slot 10
  task automatic frame(input logic [DW-1:0] l, input logic [DW-1:0] r);
    for (int k = 0; k < FL; k++) begin
      @(negedge clk);
      fcnt = k;
      frame_clk = (k < FL / 2);
      word_clk  = (k >= 4) && (k < 4 + FL / 2);
      smp_valid = (k == 10);
      if (k == 10) begin
        bit z;
        smp_l = l; smp_r = r;
        z = dig_rst || (force_left > 0);
        if (force_left > 0) force_left--;
        sb_q.push_back(z ? '0 : {l, r});
      end
    end
    @(posedge clk); #3;
  endtask

  task automatic frames(input int n, input logic [DW-1:0] l, input logic [DW-1:0] r);
    for (int i = 0; i < n; i++) frame(l, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    #3;
    chk("reset zero_flag_l", zero_flag_l, 0);
    chk("reset phase_rst", phase_rst, 0);
    chk("reset dig_rst", dig_rst, 0);
    chk("reset out_valid", out_valid, 0);
    @(negedge clk); rst = 0;

    // R3: no realignment while samples are nonzero
    frames(20, 16'h1234, 16'h0ABC);
    chk("R3 no pulse with flags low", pulses, 0);
    p0 = phase_cnt;
    frame(16'h0001, 16'h0002);
    chk("R11 counter wraps once per frame", int'(phase_cnt), p0);

    // R1: per-channel zero runs
    frames(ZR - 1, 16'h0000, 16'h0007);
    chk("R1 left flag low after ZR-1 zeros", zero_flag_l, 0);
    frame(16'h0000, 16'h0007);
    chk("R1 left flag high after ZR zeros", zero_flag_l, 1);
    chk("R1 right flag low on nonzero", zero_flag_r, 0);
    frames(ZR - 1, 16'h0000, 16'h0000);
    chk("R1 right flag low after ZR-1 zeros", zero_flag_r, 0);
    frame(16'h0000, 16'h0000);
    chk("R1 right flag high after ZR zeros", zero_flag_r, 1);
    chk("R3 no pulse until both flags", pulses, 0);

    // R3/R5: realign on next standard edge, then forced zeros
    frames(5, 16'h0011, 16'h0022);
    chk("R3 one pulse after both flags", pulses, 1);
    chk("R2 std rising edge slot", last_fcnt, 2);
    chk("R11 aligned counter at frame end", int'(phase_cnt), FL - 2);
    chk("R1 flag cleared by nonzero", zero_flag_l, 0);

    // R4: aligned counter is not reloaded
    pulses = 0;
    frames(ZR + 4, 16'h0000, 16'h0000);
    chk("R4 no pulse when in phase", pulses, 0);

    // R2: falling frame edge and word clock edge
    edge_mode = 2'd1;
    frames(2, 16'h0000, 16'h0000);
    chk("R2 I2S one pulse", pulses, 1);
    chk("R2 I2S falling edge slot", last_fcnt, 10);
    pulses = 0; edge_mode = 2'd2;
    frames(2, 16'h0000, 16'h0000);
    chk("R2 word clock one pulse", pulses, 1);
    chk("R2 word clock rising slot", last_fcnt, 6);

    // R9: disabled sync
    pulses = 0; sync_en = 0; edge_mode = 2'd0;
    frames(2, 16'h0000, 16'h0000);
    chk("R9 no pulse when disabled", pulses, 0);
    sync_en = 1;
    frames(2, 16'h0000, 16'h0000);
    chk("R9 pulse after re-enable", pulses, 1);
    chk("R2 std slot after re-enable", last_fcnt, 2);

    // soft reset sequence (R6, R7, R8)
    frames(3, 16'h0333, 16'h0444);
    pulses = 0; edge_mode = 2'd1;
    frame(16'h0555, 16'h0666);
    chk("R3 no pulse with flags low in I2S", pulses, 0);
    soft_run = 0;
    frame(16'h0101, 16'h0202);
    chk("R6 left flag on soft reset", zero_flag_l, 1);
    chk("R6 right flag on soft reset", zero_flag_r, 1);
    chk("R6 realign during soft reset", pulses, 1);
    chk("R7 dig_rst low after 1 strobe", dig_rst, 0);
    frame(16'h0303, 16'h0404);
    chk("R7 dig_rst low after 2 strobes", dig_rst, 0);
    frame(16'h0505, 16'h0606);
    chk("R7 dig_rst high at 3rd strobe", dig_rst, 1);
    frame(16'h0707, 16'h0808);
    soft_run = 1;
    frame(16'h0909, 16'h0A0A);
    chk("R7 dig_rst held after 1 release strobe", dig_rst, 1);
    frame(16'h0B0B, 16'h0C0C);
    chk("R7 dig_rst low at 2nd release strobe", dig_rst, 0);
    chk("R8 flags still held", zero_flag_l, 1);
    frame(16'h0D0D, 16'h0E0E);
    chk("R8 flags held 1 strobe after release", zero_flag_r, 1);
    frame(16'h0F0F, 16'h1010);
    chk("R8 left flag dropped", zero_flag_l, 0);
    chk("R8 right flag dropped", zero_flag_r, 0);
    frames(2, 16'h1111, 16'h2222);
    repeat (3) @(posedge clk);
    #3;
    chk("R10 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule